// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block makes the serial clock for an I2C bus master from a fast reference clock. A 5-bit divider code and a speed-mode select set the clock timing. In standard mode a period lasts eight reference cycles per unit of code. In high-speed mode a period lasts four reference cycles per unit of code. Code 5 in high-speed mode is a special case: the period is 10 cycles, with 4 high and 6 low. Every other legal setting gives equal high and low phases. Codes below 3 are refused. The block raises an error flag and leaves the line released.

The block drives the bus open-drain style: it only pulls the line low or lets it go. It watches a sampled copy of the bus line. After it releases SCL, the high phase starts counting only once the line really reads high. A slave or another master can therefore stretch the low phase, and the high phase keeps its nominal length. A new mode or code is taken at the next falling edge of SCL, so a period is never cut short. Dropping the enable releases the line in the same cycle. The next enable starts with a full high phase. Two one-cycle strobes mark the falling and rising edges of SCL for the data logic that sits alongside.

The controller has four states:
- `ST_OFF`: disabled or illegal code, line released.
- `ST_HIGH`: counting the high phase.
- `ST_LOW`: driving low and counting the low phase.
- `ST_WAIT`: released, waiting for the bus to read high.

Its transitions are:
- OFF→HIGH on enable with a legal code.
- HIGH→LOW when the high count completes.
- LOW→WAIT when the low count completes.
- WAIT→HIGH when the bus reads high. That cycle is the first high cycle.
- Any state→OFF when enable drops or the code becomes illegal.

Top module: `scl_clkgen`

## Requirements
- R1: In standard mode (`hs_mode`=0) with legal code N, SCL is low for 4·N and high for 4·N reference cycles (period 8·N).
- R2: In high-speed mode (`hs_mode`=1) with legal code N ≠ 5, SCL is low for 2·N and high for 2·N cycles (period 4·N).
- R3: In high-speed mode with code 5, SCL is high for 4 and low for 6 cycles (period 10).
- R4: Codes 0, 1 and 2 set `cfg_err`=1 in either mode, and `scl_drive_low` stays 0 while such a code is applied. Loading a legal code clears `cfg_err` and restarts the clock.
- R5: If the bus line stays low for K cycles after the block releases it, the observed low phase grows by K cycles. The following high phase keeps its nominal length.
- R6: A change of `hs_mode` or `div_code` during a high phase does not alter that high phase. The new setting governs the low phase that begins at the next falling edge, and the high phase after it.
- R7: With `en`=0, `scl_drive_low` is 0 in the same cycle. After `en` returns to 1, the line stays released for exactly one full nominal high phase before the first fall.
- R8: `scl_fall` is 1 exactly in the first cycle of each driven-low phase. `scl_rise` is 1 exactly in the first cycle the released line reads high. The two are never 1 together.
- R9: During and just after reset, `scl_drive_low`, `scl_rise` and `scl_fall` are 0, and `cfg_err` follows the applied code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock generation enable |
| hs_mode | input | 1 | 0 = standard mode, 1 = high-speed mode |
| div_code | input | 5 | Divider code N (legal values 3 to 31) |
| scl_in | input | 1 | Sampled level of the bus SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| cfg_err | output | 1 | Applied divider code is illegal |
| scl_rise | output | 1 | One-cycle strobe at the SCL rising edge |
| scl_fall | output | 1 | One-cycle strobe at the SCL falling edge |

## Verification
The bench measures low and high run lengths on the bus line for each mode and code in a vector table, including the asymmetric high-speed code 5. A generator that used the 50% rule there would show 5/5 instead of 4/6. Stretching is applied after release: a design that counted the high phase from the release instead of from the line going high would shorten the high phase. A mid-high-phase configuration change checks that the old high phase completes. A design that took the new setting at once would cut that phase to the new length. The illegal codes, the same-cycle enable release and the full first high phase after re-enable are tested directly. A design that got these wrong would pulse the line, release it one cycle late, or start with a runt high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_WAIT = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
    parameter int CODE_W    = 5,
    parameter int CNT_W     = 7,
    parameter int MIN_CODE  = 3,
    parameter int FAST_CODE = 5,
    parameter int FAST_HIGH = 4,
    parameter int FAST_LOW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              hs_mode,
    input  logic [CODE_W-1:0] div_code,
    output logic              illegal,
    output logic [CNT_W-1:0]  high_len,
    output logic [CNT_W-1:0]  low_len
);

    logic              act_hs;
    logic [CODE_W-1:0] act_code;
    logic [CNT_W-1:0]  code_ext;
    logic              fast_case;

    assign illegal = (div_code < CODE_W'(MIN_CODE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_hs   <= 1'b0;
            act_code <= CODE_W'(MIN_CODE);
        end else if (load && !illegal) begin
            act_hs   <= hs_mode;
            act_code <= div_code;
        end
    end

    assign code_ext  = CNT_W'(act_code);
    assign fast_case = act_hs && (act_code == CODE_W'(FAST_CODE));

    always_comb begin
        if (fast_case) begin
            high_len = CNT_W'(FAST_HIGH);
            low_len  = CNT_W'(FAST_LOW);
        end else if (act_hs) begin
            high_len = code_ext << 1;
            low_len  = code_ext << 1;
        end else begin
            high_len = code_ext << 2;
            low_len  = code_ext << 2;
        end
    end

endmodule

// File: rtl/scl_fsm.sv
module scl_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             illegal,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] high_len,
    input  logic [CNT_W-1:0] low_len,
    output logic             cfg_load,
    output logic             drive_low,
    output logic             rise,
    output logic             fall
);

    scl_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             run;
    logic             high_done;
    logic             low_done;

    assign run       = en && !illegal;
    assign high_done = scl_in && (cnt == high_len - CNT_W'(1));
    assign low_done  = (cnt == low_len - CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_OFF: begin
                cnt_nx = '0;
                if (run) state_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (high_done) begin
                    state_nx = ST_LOW;
                    cnt_nx   = '0;
                end else if (scl_in) begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            ST_LOW: begin
                if (low_done) begin
                    state_nx = ST_WAIT;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            ST_WAIT: begin
                if (scl_in) begin
                    state_nx = ST_HIGH;
                    cnt_nx   = CNT_W'(1);
                end
            end
            default: begin
                state_nx = ST_OFF;
                cnt_nx   = '0;
            end
        endcase
        if (!run) begin
            state_nx = ST_OFF;
            cnt_nx   = '0;
        end
    end

    // outputs
    always_comb begin
        drive_low = run && (state == ST_LOW);
        fall      = run && (state == ST_LOW) && (cnt == '0);
        rise      = run && (state == ST_WAIT) && scl_in;
        cfg_load  = (state == ST_OFF) || (run && (state == ST_HIGH) && high_done);
    end

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int CODE_W    = 5,
    parameter int MIN_CODE  = 3,
    parameter int FAST_CODE = 5,
    parameter int FAST_HIGH = 4,
    parameter int FAST_LOW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hs_mode,
    input  logic [CODE_W-1:0] div_code,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              cfg_err,
    output logic              scl_rise,
    output logic              scl_fall
);

    localparam int CNT_W = CODE_W + 2;

    logic             illegal;
    logic             cfg_load;
    logic [CNT_W-1:0] high_len;
    logic [CNT_W-1:0] low_len;

    scl_cfg_hold #(
        .CODE_W   (CODE_W),
        .CNT_W    (CNT_W),
        .MIN_CODE (MIN_CODE),
        .FAST_CODE(FAST_CODE),
        .FAST_HIGH(FAST_HIGH),
        .FAST_LOW (FAST_LOW)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .hs_mode (hs_mode),
        .div_code(div_code),
        .illegal (illegal),
        .high_len(high_len),
        .low_len (low_len)
    );

    scl_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .illegal  (illegal),
        .scl_in   (scl_in),
        .high_len (high_len),
        .low_len  (low_len),
        .cfg_load (cfg_load),
        .drive_low(scl_drive_low),
        .rise     (scl_rise),
        .fall     (scl_fall)
    );

    assign cfg_err = illegal;

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int MIN_HIGH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_drive_low,
    input logic cfg_err,
    input logic scl_rise,
    input logic scl_fall
);

    logic [7:0] high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                high_run <= '0;
        else if (!scl_in)          high_run <= '0;
        else if (high_run != 8'hFF) high_run <= high_run + 8'd1;
    end

    p_err_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !scl_drive_low);

    p_off_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !scl_drive_low);

    p_fall_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> scl_drive_low);

    p_fall_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !$past(scl_drive_low)) |-> scl_fall);

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    p_rise_on_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (scl_in && !scl_drive_low));

    p_high_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (high_run >= 8'(MIN_HIGH)));

endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .scl_in       (scl_in),
    .scl_drive_low(scl_drive_low),
    .cfg_err      (cfg_err),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall)
);

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       hs_mode = 1'b0;
    logic [4:0] div_code = 5'd5;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, cfg_err, scl_rise, scl_fall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign scl_in = ~scl_drive_low & ~stretch;

    scl_clkgen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .hs_mode      (hs_mode),
        .div_code     (div_code),
        .scl_in       (scl_in),
        .scl_drive_low(scl_drive_low),
        .cfg_err      (cfg_err),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall)
    );

    // hs, code, expected high, expected low
    localparam int VEC [7][4] = '{
        '{0,  5,  20,  20},   // R1
        '{0,  3,  12,  12},   // R1
        '{0, 31, 124, 124},   // R1
        '{1,  3,   6,   6},   // R2
        '{1,  4,   8,   8},   // R2
        '{1,  6,  12,  12},   // R2
        '{1,  5,   4,   6}    // R3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic measure(input int n, output int lo, output int hi,
                           output bit rise_ok, output bit fall_ok);
        int rel;
        do tick(); while (!scl_fall);
        if (n > 0) stretch = 1'b1;
        #1;
        rel = 0; lo = 0; hi = 0;
        while (!scl_in) begin
            lo++;
            @(negedge clk);
            if (stretch && !scl_drive_low) begin
                if (rel == n) stretch = 1'b0;
                else rel++;
            end
            #1;
        end
        rise_ok = scl_rise;
        while (scl_in) begin
            hi++;
            tick();
        end
        fall_ok = scl_fall;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo, hi, hi2, n;
        bit r_ok, f_ok, seen;

        // R9: reset state
        repeat (3) tick();
        chk(!scl_drive_low, "R9 drive_low in reset", scl_drive_low, 0);
        chk(!scl_rise && !scl_fall, "R9 strobes in reset", {scl_rise, scl_fall}, 0);
        chk(!cfg_err, "R9 cfg_err legal code", cfg_err, 0);
        rst_n = 1'b1;
        tick();
        chk(!scl_drive_low, "R9 drive_low after reset", scl_drive_low, 0);

        // R1 R2 R3 R8: table walk
        en = 1'b1;
        foreach (VEC[i]) begin
            hs_mode  = VEC[i][0][0];
            div_code = 5'(VEC[i][1]);
            measure(0, lo, hi, r_ok, f_ok);
            chk(lo == VEC[i][3], "R1/R2/R3 low phase", lo, VEC[i][3]);
            chk(hi == VEC[i][2], "R1/R2/R3 high phase", hi, VEC[i][2]);
            chk(r_ok && f_ok, "R8 edge strobes", {r_ok, f_ok}, 3);
        end

        // R5: stretching
        hs_mode = 1'b1; div_code = 5'd4;
        measure(0, lo, hi, r_ok, f_ok);
        measure(7, lo, hi, r_ok, f_ok);
        chk(lo == 15, "R5 stretched low hs", lo, 15);
        chk(hi == 8, "R5 high kept hs", hi, 8);
        chk(r_ok, "R5 rise at bus high", r_ok, 1);
        hs_mode = 1'b0; div_code = 5'd3;
        measure(0, lo, hi, r_ok, f_ok);
        measure(3, lo, hi, r_ok, f_ok);
        chk(lo == 15, "R5 stretched low std", lo, 15);
        chk(hi == 12, "R5 high kept std", hi, 12);

        // R6: change during high phase
        hs_mode = 1'b0; div_code = 5'd5;
        measure(0, lo, hi, r_ok, f_ok);
        do tick(); while (!scl_rise);
        hs_mode = 1'b1; div_code = 5'd3;
        #1;
        hi = 0;
        while (scl_in) begin hi++; tick(); end
        lo = 0;
        while (!scl_in) begin lo++; tick(); end
        hi2 = 0;
        while (scl_in) begin hi2++; tick(); end
        chk(hi == 20, "R6 current high kept", hi, 20);
        chk(lo == 6, "R6 new low at fall", lo, 6);
        chk(hi2 == 6, "R6 new high after fall", hi2, 6);

        // R7: disable during low, re-enable
        hs_mode = 1'b1; div_code = 5'd6;
        measure(0, lo, hi, r_ok, f_ok);
        do tick(); while (!scl_fall);
        tick();
        chk(scl_drive_low, "R7 low before disable", scl_drive_low, 1);
        en = 1'b0;
        #1;
        chk(!scl_drive_low, "R7 same-cycle release", scl_drive_low, 0);
        seen = 1'b0;
        repeat (5) begin tick(); if (scl_drive_low || scl_fall || scl_rise) seen = 1'b1; end
        chk(!seen, "R7 idle while disabled", seen, 0);
        en = 1'b1;
        n = 0;
        do begin tick(); if (!scl_fall) n++; end while (!scl_fall);
        chk(n == 12, "R7 full high after enable", n, 12);

        // R4: illegal codes
        for (int c = 0; c < 3; c++) begin
            hs_mode  = c[0];
            div_code = 5'(c);
            #1;
            chk(cfg_err, "R4 cfg_err on illegal code", cfg_err, 1);
            chk(!scl_drive_low, "R4 released on illegal code", scl_drive_low, 0);
            seen = 1'b0;
            repeat (40) begin tick(); if (scl_drive_low || scl_fall || scl_rise) seen = 1'b1; end
            chk(!seen, "R4 no clock on illegal code", seen, 0);
        end
        hs_mode = 1'b0; div_code = 5'd3;
        #1;
        chk(!cfg_err, "R4 cfg_err cleared", cfg_err, 0);
        measure(0, lo, hi, r_ok, f_ok);
        chk(lo == 12 && hi == 12, "R4 clock restarts", lo + hi, 24);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule